// File: doc/BRIEF.md
# UART Line Status and Modem Control Registers

This block sits between the CPU register port of a FIFO-buffered UART and its receive and transmit engines. It turns pulses from the receiver into per-character error tracking and status bits. It tracks the transmit holding FIFO and shift register, and presents the result as one read-only 8-bit status byte. A small modem control register drives four active-low modem outputs.

The receiver reports each character with a push pulse, which carries that character's parity-error, framing-error and break flags. The receive FIFO reports each character removed by the CPU with a pop pulse. The block keeps a shadow queue of the error flags, one entry per queued character, together with a count of queued characters that carry any error. The transmit side reports three pulses: a CPU write into the holding FIFO, a word moving into the shift register, and the shift register finishing. It also reports the current holding FIFO level.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status byte reads 0x06 (both transmitter-empty bits set, everything else clear). The modem control register reads 0x00, and all four modem pins are high.
- R2: Status bit 7 (data ready) is 1 exactly while at least one character is queued. A push when the queue is not full sets it, and popping the last character clears it.
- R3: Status bits 3 (break), 4 (framing) and 5 (parity) show the flags of the character at the queue head. They read 0 when the queue is empty.
- R4: Status bit 0 (receive FIFO error) sets when a character with any error flag is accepted. A status read clears it only if no queued character carries an error at the time of the read.
- R5: Status bit 6 (overrun) sets when a push arrives while the queue holds RX_DEPTH characters, and that character is dropped. A status read clears it, and a new overrun in the same cycle as a read wins.
- R6: Status bit 2 (holding register empty) sets when a word moves to the shift register while the holding FIFO level is 1. A CPU load clears it, and a load wins over a simultaneous move.
- R7: Status bit 1 (transmitter empty) is 1 only when bit 2 is 1 and the shift register is empty. A move empties the shift register flag to 0, and a done pulse without a move sets it to 1.
- R8: A write at address 0 stores wdata[3:0] as the modem controls: bit 0 for DTR, bit 1 for RTS, bit 2 for OUT1 and bit 3 for OUT2. Each pin is the complement of its bit. A read at address 0 returns the four bits with the upper nibble zero.
- R9: The status byte at address 1 is read only: writes there change no status bit and no modem output.
- R10: A pop while the queue is empty has no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 1 | Register select: 0 modem control, 1 status |
| cpu_rd | input | 1 | Read strobe (a status read triggers the clear-on-read bits) |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register (combinational) |
| rx_push | input | 1 | Receiver delivered one character |
| rx_pe | input | 1 | Parity error flag of the pushed character |
| rx_fe | input | 1 | Framing error flag of the pushed character |
| rx_bi | input | 1 | Break flag of the pushed character |
| rx_pop | input | 1 | CPU removed the head character |
| tx_load | input | 1 | CPU wrote a word into the holding FIFO |
| tx_move | input | 1 | A word moved from the holding FIFO to the shift register |
| tx_done | input | 1 | Shift register finished its word |
| tx_level | input | TX_LVL_W | Holding FIFO level before the move |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |

## Verification
Every cycle, the assertions check the following:
- an accepted push raises data ready;
- a push into a full queue raises overrun;
- an accepted errored push raises the FIFO-error bit;
- head flags stay zero while the queue is empty;
- a load clears holding-register-empty;
- transmitter-empty never stands without holding-register-empty;
- each modem pin is the complement of the last control write.

Some behaviours need history that no single-cycle property holds, so only the bench scenarios show them:
- the conditional clear of the FIFO-error bit while older errored characters remain queued;
- the head flags tracking each character as it reaches the front;
- the dropped character after an overrun;
- read-only behaviour of the status byte.

A reference model in the bench follows exhaustive sweeps of flag patterns, modem values and transmit pulse combinations, and then a long mixed random stream.

// File: rtl/uls_pkg.sv
package uls_pkg;

  typedef enum logic {
    ADDR_MCTL = 1'b0,
    ADDR_STAT = 1'b1
  } reg_addr_t;

  typedef struct packed {
    logic bi;
    logic fe;
    logic pe;
  } rx_flags_t;

  localparam int STAT_FERR = 0;
  localparam int STAT_TEMT = 1;
  localparam int STAT_THRE = 2;
  localparam int STAT_BI   = 3;
  localparam int STAT_FE   = 4;
  localparam int STAT_PE   = 5;
  localparam int STAT_OE   = 6;
  localparam int STAT_DR   = 7;

  localparam int MCTL_W = 4;

endpackage

// File: rtl/uls_rx_errq.sv
module uls_rx_errq
  import uls_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              push,
  input  rx_flags_t                         flags_in,
  input  logic                              pop,
  output rx_flags_t                         head_flags,
  output logic                              not_empty,
  output logic                              err_pending,
  output logic                              accept_err,
  output logic                              drop,
  output logic [$clog2(DEPTH+1)-1:0]        count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rx_flags_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ecnt_q, ecnt_d;
  logic             full, empty, do_push, do_pop, push_err, head_err;
  rx_flags_t        head_raw;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (cnt_q == FULL_CNT);
  assign empty    = (cnt_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign push_err = |flags_in;
  assign head_raw = mem[rd_q];
  assign head_err = |head_raw;

  always_comb begin
    wr_d   = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d   = do_pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d  = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    ecnt_d = ecnt_q + CNT_W'(do_push && push_err) - CNT_W'(do_pop && head_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      ecnt_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      ecnt_q <= ecnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_q] <= flags_in;
    end
  end

  assign head_flags  = empty ? '0 : head_raw;
  assign not_empty   = !empty;
  assign err_pending = (ecnt_q != '0);
  assign accept_err  = do_push && push_err;
  assign drop        = push && full;
  assign count       = cnt_q;

endmodule

// File: rtl/uls_rx_sticky.sv
module uls_rx_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_err,
  input  logic err_pending,
  input  logic drop,
  input  logic stat_rd,
  output logic fifo_err,
  output logic overrun
);

  logic ferr_q, ferr_d, oe_q, oe_d;

  always_comb begin
    ferr_d = ferr_q;
    if (accept_err) begin
      ferr_d = 1'b1;
    end else if (stat_rd && !err_pending) begin
      ferr_d = 1'b0;
    end
    oe_d = oe_q;
    if (drop) begin
      oe_d = 1'b1;
    end else if (stat_rd) begin
      oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      ferr_q <= ferr_d;
      oe_q   <= oe_d;
    end
  end

  assign fifo_err = ferr_q;
  assign overrun  = oe_q;

endmodule

// File: rtl/uls_tx_track.sv
module uls_tx_track #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             move,
  input  logic             done,
  input  logic [LVL_W-1:0] level,
  output logic             hold_empty,
  output logic             all_empty
);

  localparam logic [LVL_W-1:0] ONE_LEFT = LVL_W'(1);

  logic he_q, he_d, sh_q, sh_d;

  always_comb begin
    he_d = he_q;
    if (load) begin
      he_d = 1'b0;
    end else if (move && (level == ONE_LEFT)) begin
      he_d = 1'b1;
    end
    sh_d = sh_q;
    if (move) begin
      sh_d = 1'b0;
    end else if (done) begin
      sh_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      he_q <= 1'b1;
      sh_q <= 1'b1;
    end else begin
      he_q <= he_d;
      sh_q <= sh_d;
    end
  end

  assign hold_empty = he_q;
  assign all_empty  = he_q && sh_q;

endmodule

// File: rtl/uls_modem_ctl.sv
module uls_modem_ctl
  import uls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MCTL_W-1:0] wdata,
  output logic [MCTL_W-1:0] ctrl,
  output logic [MCTL_W-1:0] pins_n
);

  logic [MCTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = wr_en ? wdata : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign ctrl = ctl_q;

  for (genvar i = 0; i < MCTL_W; i++) begin : g_pin
    assign pins_n[i] = ~ctl_q[i];
  end

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int TX_LVL_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [7:0]          cpu_wdata,
  output logic [7:0]          cpu_rdata,
  input  logic                rx_push,
  input  logic                rx_pe,
  input  logic                rx_fe,
  input  logic                rx_bi,
  input  logic                rx_pop,
  input  logic                tx_load,
  input  logic                tx_move,
  input  logic                tx_done,
  input  logic [TX_LVL_W-1:0] tx_level,
  output logic                dtr_n,
  output logic                rts_n,
  output logic                out1_n,
  output logic                out2_n
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic              stat_rd, mctl_wr;
  rx_flags_t         push_flags, head_flags;
  logic              not_empty, err_pending, accept_err, drop;
  logic [CNT_W-1:0]  rx_count;
  logic              fifo_err, overrun, hold_empty, all_empty;
  logic [MCTL_W-1:0] mctl, pins_n;
  logic [7:0]        stat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  assign stat_rd    = cpu_rd && (reg_addr_t'(cpu_addr) == ADDR_STAT);
  assign mctl_wr    = cpu_wr && (reg_addr_t'(cpu_addr) == ADDR_MCTL);
  assign push_flags = '{bi: rx_bi, fe: rx_fe, pe: rx_pe};

  uls_rx_errq #(.DEPTH(RX_DEPTH)) u_errq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push       (rx_push),
    .flags_in   (push_flags),
    .pop        (rx_pop),
    .head_flags (head_flags),
    .not_empty  (not_empty),
    .err_pending(err_pending),
    .accept_err (accept_err),
    .drop       (drop),
    .count      (rx_count)
  );

  uls_rx_sticky u_sticky (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept_err (accept_err),
    .err_pending(err_pending),
    .drop       (drop),
    .stat_rd    (stat_rd),
    .fifo_err   (fifo_err),
    .overrun    (overrun)
  );

  uls_tx_track #(.LVL_W(TX_LVL_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (tx_load),
    .move      (tx_move),
    .done      (tx_done),
    .level     (tx_level),
    .hold_empty(hold_empty),
    .all_empty (all_empty)
  );

  uls_modem_ctl u_mctl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (mctl_wr),
    .wdata (cpu_wdata[MCTL_W-1:0]),
    .ctrl  (mctl),
    .pins_n(pins_n)
  );

  always_comb begin
    stat_byte            = '0;
    stat_byte[STAT_FERR] = fifo_err;
    stat_byte[STAT_TEMT] = all_empty;
    stat_byte[STAT_THRE] = hold_empty;
    stat_byte[STAT_BI]   = head_flags.bi;
    stat_byte[STAT_FE]   = head_flags.fe;
    stat_byte[STAT_PE]   = head_flags.pe;
    stat_byte[STAT_OE]   = overrun;
    stat_byte[STAT_DR]   = not_empty;
  end

  always_comb begin
    if (reg_addr_t'(cpu_addr) == ADDR_STAT) begin
      cpu_rdata = stat_byte;
    end else begin
      cpu_rdata = {{(8-MCTL_W){1'b0}}, mctl};
    end
  end

  assign dtr_n  = pins_n[0];
  assign rts_n  = pins_n[1];
  assign out1_n = pins_n[2];
  assign out2_n = pins_n[3];

endmodule

// File: rtl/uls_checker.sv
module uls_checker #(
  parameter int RX_DEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cpu_addr,
  input logic                         cpu_wr,
  input logic [7:0]                   cpu_wdata,
  input logic                         rx_push,
  input logic                         rx_pe,
  input logic                         rx_fe,
  input logic                         rx_bi,
  input logic                         tx_load,
  input logic [7:0]                   stat,
  input logic [3:0]                   pins,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_count
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RX_DEPTH);

  p_dr_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count != FULL_CNT) |=> stat[7]);

  p_head_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[7] |-> (stat[5:3] == 3'b000));

  p_ferr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count != FULL_CNT && (rx_pe || rx_fe || rx_bi)) |=> stat[0]);

  p_oe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count == FULL_CNT) |=> stat[6]);

  p_thre_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !stat[2]);

  p_temt_thre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> stat[2]);

  p_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr) |=> (pins == ~$past(cpu_wdata[3:0])));

endmodule

bind uart_line_status uls_checker #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cpu_addr (cpu_addr),
  .cpu_wr   (cpu_wr),
  .cpu_wdata(cpu_wdata),
  .rx_push  (rx_push),
  .rx_pe    (rx_pe),
  .rx_fe    (rx_fe),
  .rx_bi    (rx_bi),
  .tx_load  (tx_load),
  .stat     (stat_byte),
  .pins     ({out2_n, out1_n, rts_n, dtr_n}),
  .rx_count (rx_count)
);

// File: tb/uart_line_status_tb.sv
module uart_line_status_tb;

  localparam int DEPTH = 4;

  logic       clk, rst_n;
  logic       cpu_addr, cpu_rd, cpu_wr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       rx_push, rx_pe, rx_fe, rx_bi, rx_pop;
  logic       tx_load, tx_move, tx_done;
  logic [4:0] tx_level;
  logic       dtr_n, rts_n, out1_n, out2_n;

  int checks = 0;
  int fails  = 0;

  bit [2:0] mq[$];
  bit       m_ferr, m_oe, m_thre, m_tsr;
  bit [3:0] m_mctl;

  uart_line_status #(.RX_DEPTH(DEPTH), .TX_LVL_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_push(rx_push), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_bi(rx_bi),
    .rx_pop(rx_pop), .tx_load(tx_load), .tx_move(tx_move),
    .tx_done(tx_done), .tx_level(tx_level), .dtr_n(dtr_n),
    .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit [7:0] m_stat();
    bit [2:0] h;
    h = (mq.size() != 0) ? mq[0] : 3'b000;
    return {mq.size() != 0, m_oe, h[0], h[1], h[2], m_thre, m_thre & m_tsr, m_ferr};
  endfunction

  function automatic int m_errcnt();
    int n = 0;
    foreach (mq[i]) if (mq[i] != 0) n++;
    return n;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_addr = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
    rx_push = 0; rx_pe = 0; rx_fe = 0; rx_bi = 0; rx_pop = 0;
    tx_load = 0; tx_move = 0; tx_done = 0; tx_level = 0;
  endtask

  // f = {bi, fe, pe}
  task automatic step(input string tag, input bit a, input bit rd, input bit wr,
                      input bit [7:0] wd, input bit push, input bit [2:0] f,
                      input bit pop, input bit load, input bit move,
                      input bit done, input bit [4:0] lvl);
    bit full;
    int ecnt;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    rx_push = push; rx_bi = f[2]; rx_fe = f[1]; rx_pe = f[0]; rx_pop = pop;
    tx_load = load; tx_move = move; tx_done = done; tx_level = lvl;
    #1;
    if (rd) check(tag, cpu_rdata, a ? m_stat() : {4'b0, m_mctl});
    @(posedge clk);
    full = (mq.size() == DEPTH);
    ecnt = m_errcnt();
    if (push && full) m_oe = 1;
    else if (rd && a) m_oe = 0;
    if (push && !full && f != 0) m_ferr = 1;
    else if (rd && a && ecnt == 0) m_ferr = 0;
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (push && !full) mq.push_back(f);
    if (load) m_thre = 0;
    else if (move && lvl == 1) m_thre = 1;
    if (move) m_tsr = 0;
    else if (done) m_tsr = 1;
    if (wr && !a) m_mctl = wd[3:0];
    #1;
    if (wr) check({tag, " pins"}, {4'b0, out2_n, out1_n, rts_n, dtr_n}, {4'b0, ~m_mctl});
    idle();
  endtask

  task automatic rd_stat(input string tag);
    step(tag, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic peek_stat(input string tag);
    @(negedge clk); cpu_addr = 1; #1;
    check(tag, cpu_rdata, m_stat());
    idle();
  endtask
  task automatic push(input bit [2:0] f);
    step("R2 push", 0, 0, 0, 0, 1, f, 0, 0, 0, 0, 0);
  endtask
  task automatic pop();
    step("R2 pop", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_ferr = 0; m_oe = 0; m_thre = 1; m_tsr = 1; m_mctl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk); cpu_addr = 1; #1; check("R1 status", cpu_rdata, 8'h06);
    cpu_addr = 0; #1; check("R1 mctl", cpu_rdata, 8'h00);
    check("R1 pins", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    idle();

    // R8 full sweep of control writes with readback
    for (int v = 0; v < 256; v++) begin
      step("R8 write", 0, 0, 1, 8'(v), 0, 0, 0, 0, 0, 0, 0);
      step("R8 readback", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end

    // R9 writes to status change nothing
    push(3'b101);
    for (int v = 0; v < 256; v += 17) begin
      step("R9 write ignored", 1, 0, 1, 8'(v), 0, 0, 0, 0, 0, 0, 0);
      peek_stat("R9 status unchanged");
      check("R9 pins unchanged", {4'b0, out2_n, out1_n, rts_n, dtr_n}, {4'b0, ~m_mctl});
    end
    pop();
    rd_stat("R4 clear after drain");

    // R3 / R4 every flag pattern at head, alone
    for (int f = 0; f < 8; f++) begin
      push(3'(f));
      peek_stat("R3 head flags");
      rd_stat("R4 read with char queued");
      peek_stat("R4 ferr held while queued");
      pop();
      peek_stat("R10 empty after pop");
      rd_stat("R4 read after drain");
      peek_stat("R4 ferr cleared");
    end

    // R3 / R4 errored char behind clean ones, then ahead of clean ones
    for (int f = 1; f < 8; f++) begin
      push(0); push(0); push(3'(f)); push(0);
      for (int k = 0; k < 4; k++) begin
        rd_stat("R4 conditional clear");
        peek_stat("R3 head tracks queue");
        pop();
      end
      rd_stat("R4 final clear");
      peek_stat("R2 dr clear");
    end

    // R5 overrun, dropped char, clear on read, set wins over read
    for (int k = 0; k < DEPTH; k++) push(3'(k));
    push(3'b111);
    peek_stat("R5 overrun set");
    step("R5 overrun with read", 1, 1, 0, 0, 1, 3'b111, 0, 0, 0, 0, 0);
    peek_stat("R5 set wins");
    rd_stat("R5 read clears");
    peek_stat("R5 overrun cleared");
    for (int k = 0; k < DEPTH; k++) begin peek_stat("R5 dropped char absent"); pop(); end
    // R10 pop when empty
    pop(); pop();
    peek_stat("R10 empty pop ignored");
    rd_stat("R10 read");

    // R6 / R7 exhaustive transmit pulse combinations
    for (int rep = 0; rep < 3; rep++)
      for (int c = 0; c < 32; c++) begin
        step("R6 tx combo", 1, 0, 0, 0, 0, 0, 0, c[0], c[1], c[2], 5'(c[4:3]));
        peek_stat("R7 tx status");
      end
    step("R6 load", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R6 move lvl2", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 2);
    peek_stat("R6 not yet empty");
    step("R6 move last", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    peek_stat("R7 shift busy");
    step("R7 done", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    peek_stat("R7 all empty");

    // mixed random stream
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] r = $urandom;
      step("R2 random", r[0], r[1] & r[2], r[3] & r[4] & r[5], r[13:6],
           r[14], r[17:15] & {3{r[18]}}, r[19] & r[20], r[21] & r[22],
           r[23], r[24], 5'(r[26:25]));
      peek_stat("R4 random status");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule